// File: doc/BRIEF.md
# VME Slave Access Qualifier

This block sits between a simplified VMEbus slave interface and the port of the local DRAM. For every incoming slave cycle it decides whether the cycle may reach DRAM, and it decides how the cycle is acknowledged. Two configuration registers are written over a small configuration port. The control register holds three bits: slave enable, a 16-bit-only limit, and write posting. The address-modifier enable register is eight bits wide and sets which classes of address modifier the slave answers.

Each 6-bit address modifier is split into three properties: the cycle kind (data, program, block), the address space (short, standard, extended) and the privilege (user, supervisor). A cycle is qualified only when each of the three properties matches an enabled bit in its group. A qualified read or an unposted write is passed to DRAM and acknowledged after DRAM reports ready. When posting is on, a qualified write is acknowledged at once and stored in a single-entry buffer, which then completes the DRAM write by itself.

Top module: `vme_slave_qual`

## Requirements
- R1: After reset both registers read as zero in effect: `cyc_ack` and `mem_req` are low, and a cycle with any address modifier is not answered until the slave is configured.
- R2: While control bit 0 (slave enable) is 0, no cycle produces `cyc_ack` or `mem_req`, whatever the address-modifier enables are.
- R3: Recognised modifiers are 0x29/0x2D (short, counted as data), 0x39/0x3A/0x3B and 0x3D/0x3E/0x3F (standard data/program/block), and 0x09/0x0A/0x0B and 0x0D/0x0E/0x0F (extended data/program/block). Modifier bit 2 set means supervisor. Every other code is rejected.
- R4: Enable register bits are data=0, program=1, block=2, short=3, standard=4, extended=5, user=6, supervisor=7. A cycle is accepted only when its kind hits an enabled bit in [2:0], its space hits one in [5:3], and its privilege hits one in [7:6]. If any group is all zero, no cycle is accepted.
- R5: Size codes are 0=D08 (even/odd), 1=D16, 2=D32, 3=unaligned. With control bit 1 (16-bit only) set, sizes 2 and 3 are rejected. With it clear, all four sizes are accepted.
- R6: An accepted read, or an accepted write with posting off, raises `mem_req` in the cycle after acceptance. It holds `mem_req` with a stable address until `mem_ready`. Then it gives a one-cycle `cyc_ack` in the next cycle. For a read, `cyc_rdata` carries the `mem_rdata` value sampled with `mem_ready`.
- R7: With control bit 2 (write posting) set, an accepted write gives `cyc_ack` in the cycle after acceptance while `mem_req` is still pending. The buffered address and data are then written to DRAM unchanged.
- R8: While a posted write has not yet completed, no new cycle is accepted or acknowledged. The new cycle waits until the DRAM write has drained.
- R9: A rejected cycle produces neither `cyc_ack` nor `mem_req`.
- R10: One bus cycle yields exactly one acknowledge. The next cycle is accepted only after `cyc_valid` has been dropped.
- R11: Reads are never posted. With posting on, a read still waits for DRAM and returns its data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_sel | input | 1 | 0 selects control register, 1 selects modifier enable register |
| cfg_wdata | input | 8 | Configuration write data |
| cyc_valid | input | 1 | Slave cycle present, held by the master until acknowledged |
| cyc_am | input | 6 | Address modifier of the cycle |
| cyc_addr | input | AW | Cycle address |
| cyc_size | input | 2 | Transfer size code |
| cyc_write | input | 1 | 1 for write, 0 for read |
| cyc_wdata | input | DW | Write data |
| cyc_ack | output | 1 | One-cycle acknowledge to the master |
| cyc_rdata | output | DW | Read data, valid with `cyc_ack` on reads |
| mem_req | output | 1 | DRAM request, held until `mem_ready` |
| mem_we | output | 1 | DRAM write enable |
| mem_addr | output | AW | DRAM address |
| mem_wdata | output | DW | DRAM write data |
| mem_size | output | 2 | DRAM transfer size code |
| mem_ready | input | 1 | DRAM completion |
| mem_rdata | input | DW | DRAM read data |

## Verification
The hardest situation to reach is a second cycle that arrives while a posted write is still draining. The bench sets a long DRAM latency and issues a posted write. It drops `cyc_valid` on the early acknowledge and presents a read at once. The read must wait past the remaining latency, and the scoreboard must see the write reach DRAM before the read. Group filtering is covered by walking enable masks that empty one group at a time, and by modifiers that hit only the disabled member of a group.

// File: rtl/vsq_pkg.sv
package vsq_pkg;

   typedef enum logic [1:0] {
      SZ_D08 = 2'd0,
      SZ_D16 = 2'd1,
      SZ_D32 = 2'd2,
      SZ_UAT = 2'd3
   } vsq_size_e;

   // decoded properties of one address modifier, one-hot inside each field
   typedef struct packed {
      logic       known;
      logic [2:0] kind;   // [0] data, [1] program, [2] block
      logic [2:0] space;  // [0] short, [1] standard, [2] extended
      logic [1:0] priv;   // [0] user, [1] supervisor
   } vsq_am_class_t;

   localparam int CTL_EN     = 0;
   localparam int CTL_NARROW = 1;
   localparam int CTL_POST   = 2;
   localparam int CTL_W      = 3;

   localparam int AMEN_W     = 8;

endpackage

// File: rtl/vsq_am_decode.sv
module vsq_am_decode
   import vsq_pkg::*;
#(
   parameter int AMW = 6
) (
   input  logic [AMW-1:0] am,
   output vsq_am_class_t  cls
);

   if (AMW != 6) begin : g_bad_amw
      $error("vsq_am_decode: AMW must be 6");
   end

   logic [2:0] kind_raw;
   logic [2:0] space_raw;
   logic       short_ok;

   always_comb begin
      unique case (am[1:0])
         2'b01:   kind_raw = 3'b001;
         2'b10:   kind_raw = 3'b010;
         2'b11:   kind_raw = 3'b100;
         default: kind_raw = 3'b000;
      endcase
   end

   always_comb begin
      unique case (am[5:3])
         3'b101:  space_raw = 3'b001;
         3'b111:  space_raw = 3'b010;
         3'b001:  space_raw = 3'b100;
         default: space_raw = 3'b000;
      endcase
   end

   // short space only knows the plain data access code
   assign short_ok = !space_raw[0] || (am[1:0] == 2'b01);

   always_comb begin
      cls = '0;
      if ((kind_raw != 3'b000) && (space_raw != 3'b000) && short_ok) begin
         cls.known = 1'b1;
         cls.kind  = kind_raw;
         cls.space = space_raw;
         cls.priv  = am[2] ? 2'b10 : 2'b01;
      end
   end

endmodule

// File: rtl/vsq_am_match.sv
module vsq_am_match
   import vsq_pkg::*;
(
   input  vsq_am_class_t     cls,
   input  logic [AMEN_W-1:0] am_en,
   output logic              hit
);

   logic kind_hit;
   logic space_hit;
   logic priv_hit;

   assign kind_hit  = |(am_en[2:0] & cls.kind);
   assign space_hit = |(am_en[5:3] & cls.space);
   assign priv_hit  = |(am_en[7:6] & cls.priv);

   assign hit = cls.known && kind_hit && space_hit && priv_hit;

endmodule

// File: rtl/vsq_post_buf.sv
module vsq_post_buf #(
   parameter int AW = 24,
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] in_addr,
   input  logic [DW-1:0] in_data,
   input  logic [1:0]    in_size,
   input  logic          drain,
   output logic          pend,
   output logic [AW-1:0] b_addr,
   output logic [DW-1:0] b_data,
   output logic [1:0]    b_size
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend   <= 1'b0;
         b_addr <= '0;
         b_data <= '0;
         b_size <= '0;
      end else if (load) begin
         pend   <= 1'b1;
         b_addr <= in_addr;
         b_data <= in_data;
         b_size <= in_size;
      end else if (drain) begin
         pend   <= 1'b0;
      end
   end

endmodule

// File: rtl/vme_slave_qual.sv
module vme_slave_qual
   import vsq_pkg::*;
#(
   parameter int AW        = 24,
   parameter int DW        = 32,
   parameter int AMW       = 6,
   parameter bit POST_IMPL = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_we,
   input  logic          cfg_sel,
   input  logic [7:0]    cfg_wdata,
   input  logic          cyc_valid,
   input  logic [AMW-1:0] cyc_am,
   input  logic [AW-1:0] cyc_addr,
   input  logic [1:0]    cyc_size,
   input  logic          cyc_write,
   input  logic [DW-1:0] cyc_wdata,
   output logic          cyc_ack,
   output logic [DW-1:0] cyc_rdata,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   output logic [1:0]    mem_size,
   input  logic          mem_ready,
   input  logic [DW-1:0] mem_rdata
);

   if (DW < 32) begin : g_bad_dw
      $error("vme_slave_qual: DW must be at least 32 for D32 transfers");
   end
   if (AW < 8) begin : g_bad_aw
      $error("vme_slave_qual: AW must be at least 8");
   end

   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_DIRECT  = 2'd1,
      ST_RELEASE = 2'd2
   } vsq_state_e;

   // configuration
   logic [CTL_W-1:0]  ctrl_q;
   logic [AMEN_W-1:0] amen_q;
   logic              slave_en;
   logic              narrow_only;
   logic              post_on;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         amen_q <= '0;
      end else if (cfg_we) begin
         if (cfg_sel) amen_q <= cfg_wdata[AMEN_W-1:0];
         else         ctrl_q <= cfg_wdata[CTL_W-1:0];
      end
   end

   assign slave_en    = ctrl_q[CTL_EN];
   assign narrow_only = ctrl_q[CTL_NARROW];
   assign post_on     = ctrl_q[CTL_POST] && POST_IMPL;

   // qualification
   vsq_am_class_t am_cls;
   logic          am_hit;
   logic          size_ok;
   logic          pend;
   logic          accept;
   logic          post_now;
   vsq_state_e    st_q;

   vsq_am_decode #(.AMW(AMW)) u_dec (
      .am  (cyc_am),
      .cls (am_cls)
   );

   vsq_am_match u_match (
      .cls   (am_cls),
      .am_en (amen_q),
      .hit   (am_hit)
   );

   assign size_ok  = !narrow_only ||
                     (cyc_size == SZ_D08) || (cyc_size == SZ_D16);
   assign accept   = (st_q == ST_IDLE) && cyc_valid && !pend &&
                     slave_en && am_hit && size_ok;
   assign post_now = accept && cyc_write && post_on;

   // posted write buffer
   logic [AW-1:0] b_addr;
   logic [DW-1:0] b_data;
   logic [1:0]    b_size;

   if (POST_IMPL) begin : g_post
      vsq_post_buf #(.AW(AW), .DW(DW)) u_buf (
         .clk     (clk),
         .rst_n   (rst_n),
         .load    (post_now),
         .in_addr (cyc_addr),
         .in_data (cyc_wdata),
         .in_size (cyc_size),
         .drain   (mem_ready),
         .pend    (pend),
         .b_addr  (b_addr),
         .b_data  (b_data),
         .b_size  (b_size)
      );
   end else begin : g_nopost
      assign pend   = 1'b0;
      assign b_addr = '0;
      assign b_data = '0;
      assign b_size = '0;
   end

   // cycle sequencing
   logic          ack_q;
   logic [DW-1:0] rdata_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         ack_q   <= 1'b0;
         rdata_q <= '0;
      end else begin
         ack_q <= 1'b0;
         unique case (st_q)
            ST_IDLE: begin
               if (post_now) begin
                  ack_q <= 1'b1;
                  st_q  <= ST_RELEASE;
               end else if (accept) begin
                  st_q  <= ST_DIRECT;
               end
            end
            ST_DIRECT: begin
               if (mem_ready) begin
                  ack_q <= 1'b1;
                  if (!cyc_write) rdata_q <= mem_rdata;
                  st_q  <= ST_RELEASE;
               end
            end
            ST_RELEASE: begin
               if (!cyc_valid) st_q <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign cyc_ack   = ack_q;
   assign cyc_rdata = rdata_q;

   assign mem_req   = pend || (st_q == ST_DIRECT);
   assign mem_we    = pend ? 1'b1   : cyc_write;
   assign mem_addr  = pend ? b_addr : cyc_addr;
   assign mem_wdata = pend ? b_data : cyc_wdata;
   assign mem_size  = pend ? b_size : cyc_size;

endmodule

module vsq_checker #(
   parameter int AW = 24
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cyc_ack,
   input logic          mem_req,
   input logic          mem_ready,
   input logic          mem_we,
   input logic [AW-1:0] mem_addr,
   input logic [1:0]    mem_size,
   input logic          en_bit,
   input logic          narrow_bit,
   input logic          pend
);

   assert_ack_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_ack |=> !cyc_ack);

   assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

   assert_req_needs_en_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_req) |-> $past(en_bit));

   assert_narrow_size_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_req) |-> !($past(narrow_bit) && mem_size[1]));

   assert_hold_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && !mem_ready) |=> !cyc_ack);

endmodule

bind vme_slave_qual vsq_checker #(.AW(AW)) u_vsq_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cyc_ack    (cyc_ack),
   .mem_req    (mem_req),
   .mem_ready  (mem_ready),
   .mem_we     (mem_we),
   .mem_addr   (mem_addr),
   .mem_size   (mem_size),
   .en_bit     (slave_en),
   .narrow_bit (narrow_only),
   .pend       (pend)
);

// File: tb/tb_vme_slave_qual.sv
module tb_vme_slave_qual;

   localparam int AW = 24;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic          cfg_sel = 1'b0;
   logic [7:0]    cfg_wdata = '0;
   logic          cyc_valid = 1'b0;
   logic [5:0]    cyc_am = '0;
   logic [AW-1:0] cyc_addr = '0;
   logic [1:0]    cyc_size = '0;
   logic          cyc_write = 1'b0;
   logic [DW-1:0] cyc_wdata = '0;
   logic          cyc_ack;
   logic [DW-1:0] cyc_rdata;
   logic          mem_req;
   logic          mem_we;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata;
   logic [1:0]    mem_size;
   logic          mem_ready = 1'b0;
   logic [DW-1:0] mem_rdata = '0;

   vme_slave_qual #(.AW(AW), .DW(DW)) dut (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
      .cyc_valid(cyc_valid), .cyc_am(cyc_am), .cyc_addr(cyc_addr),
      .cyc_size(cyc_size), .cyc_write(cyc_write), .cyc_wdata(cyc_wdata),
      .cyc_ack(cyc_ack), .cyc_rdata(cyc_rdata),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_size(mem_size),
      .mem_ready(mem_ready), .mem_rdata(mem_rdata)
   );

   always #2 clk = ~clk;

   typedef struct {
      logic          we;
      logic [AW-1:0] addr;
      logic [DW-1:0] data;
   } exp_item_t;

   exp_item_t exp_q[$];
   int checks = 0;
   int fails = 0;
   int mem_lat = 2;
   int req_seen = 0;
   int mem_done = 0;
   int last_wait = 0;

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] dram_word(input logic [AW-1:0] a);
      return {8'hA5, a};
   endfunction

   // DRAM model and scoreboard monitor
   initial begin
      int cnt;
      cnt = 0;
      forever begin
         @(negedge clk);
         if (mem_ready) begin
            mem_ready = 1'b0;
            cnt = 0;
            mem_done++;
         end else if (mem_req) begin
            req_seen++;
            cnt++;
            if (cnt >= mem_lat) begin
               exp_item_t e;
               mem_ready = 1'b1;
               mem_rdata = dram_word(mem_addr);
               if (exp_q.size() == 0) begin
                  check(1'b0, "R9 unexpected DRAM access", {8'h0, mem_addr}, 32'h0);
               end else begin
                  e = exp_q.pop_front();
                  check(mem_we == e.we, "R6 DRAM direction", {31'h0, mem_we}, {31'h0, e.we});
                  check(mem_addr == e.addr, "R7 DRAM address", {8'h0, mem_addr}, {8'h0, e.addr});
                  if (e.we)
                     check(mem_wdata == e.data, "R7 DRAM write data", mem_wdata, e.data);
               end
            end
         end
      end
   end

   task automatic cfg_write(input logic sel, input logic [7:0] val);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   // driver: mode 0 = direct, 1 = posted
   task automatic run_cycle(input logic [5:0] am, input logic [AW-1:0] addr,
                            input logic [1:0] sz, input logic we,
                            input logic [DW-1:0] wd, input bit exp_acc,
                            input int mode, input int hold, input string tag);
      int waited;
      bit got;
      int r0;
      int extra;
      @(negedge clk);
      cyc_am = am; cyc_addr = addr; cyc_size = sz; cyc_write = we;
      cyc_wdata = wd; cyc_valid = 1'b1;
      r0 = req_seen;
      if (exp_acc) exp_q.push_back('{we: we, addr: addr, data: wd});
      waited = 0; got = 0;
      while (!got && waited < 64) begin
         @(negedge clk);
         waited++;
         if (cyc_ack) got = 1;
      end
      last_wait = waited;
      if (exp_acc) begin
         check(got, {tag, " acknowledge"}, {31'h0, got}, 32'h1);
         if (got) begin
            if (mode == 1) begin
               check(mem_req == 1'b1, {tag, " ack before DRAM done"}, {31'h0, mem_req}, 32'h1);
               check(waited == 1, {tag, " early ack cycle"}, waited, 32'h1);
            end else begin
               check(mem_req == 1'b0, {tag, " ack after DRAM done"}, {31'h0, mem_req}, 32'h0);
            end
            if (!we)
               check(cyc_rdata == dram_word(addr), {tag, " read data"}, cyc_rdata, dram_word(addr));
            extra = 0;
            for (int i = 0; i < hold; i++) begin
               @(negedge clk);
               if (cyc_ack) extra++;
            end
            if (hold > 0)
               check(extra == 0, "R10 single ack while valid held", extra, 32'h0);
         end
      end else begin
         check(!got, {tag, " no acknowledge"}, {31'h0, got}, 32'h0);
         check(req_seen == r0, {tag, " R9 no DRAM request"}, req_seen - r0, 32'h0);
      end
      cyc_valid = 1'b0;
   endtask

   initial begin
      #(4 * 150000);
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(cyc_ack == 1'b0, "R1 reset ack low", {31'h0, cyc_ack}, 32'h0);
      check(mem_req == 1'b0, "R1 reset req low", {31'h0, mem_req}, 32'h0);
      run_cycle(6'h39, 24'h000100, 2'd2, 1'b0, 32'h0, 1'b0, 0, 0, "R1");

      // all AM classes on, slave still disabled
      cfg_write(1'b1, 8'hFF);
      run_cycle(6'h39, 24'h000104, 2'd2, 1'b0, 32'h0, 1'b0, 0, 0, "R2");
      cfg_write(1'b0, 8'h06); // narrow + post, enable off
      run_cycle(6'h39, 24'h000108, 2'd1, 1'b1, 32'h11, 1'b0, 0, 0, "R2 with other bits");

      // enable, direct mode; data + standard + user
      cfg_write(1'b0, 8'h01);
      cfg_write(1'b1, 8'h51);
      mem_lat = 3;
      run_cycle(6'h39, 24'h001000, 2'd2, 1'b0, 32'h0, 1'b1, 0, 0, "R6 read");
      run_cycle(6'h39, 24'h001004, 2'd2, 1'b1, 32'hDEADBEEF, 1'b1, 0, 0, "R6 write");
      run_cycle(6'h3D, 24'h001008, 2'd2, 1'b0, 32'h0, 1'b0, 0, 0, "R4 supervisor off");
      run_cycle(6'h3A, 24'h00100C, 2'd2, 1'b0, 32'h0, 1'b0, 0, 0, "R4 program off");
      run_cycle(6'h09, 24'h001010, 2'd2, 1'b0, 32'h0, 1'b0, 0, 0, "R4 extended off");

      // everything but block
      cfg_write(1'b1, 8'hFB);
      run_cycle(6'h29, 24'h002000, 2'd1, 1'b0, 32'h0, 1'b1, 0, 0, "R3 short user");
      run_cycle(6'h2D, 24'h002004, 2'd1, 1'b1, 32'h12345678, 1'b1, 0, 0, "R3 short super");
      run_cycle(6'h3A, 24'h002008, 2'd2, 1'b0, 32'h0, 1'b1, 0, 0, "R3 std program");
      run_cycle(6'h0E, 24'h00200C, 2'd2, 1'b0, 32'h0, 1'b1, 0, 0, "R3 ext super program");
      run_cycle(6'h0D, 24'h002010, 2'd2, 1'b1, 32'hCAFEF00D, 1'b1, 0, 0, "R3 ext super data");
      run_cycle(6'h3B, 24'h002014, 2'd2, 1'b0, 32'h0, 1'b0, 0, 0, "R4 block off");
      run_cycle(6'h3C, 24'h002018, 2'd2, 1'b0, 32'h0, 1'b0, 0, 0, "R3 unknown 3C");
      run_cycle(6'h2A, 24'h00201C, 2'd2, 1'b0, 32'h0, 1'b0, 0, 0, "R3 short program");
      run_cycle(6'h00, 24'h002020, 2'd2, 1'b0, 32'h0, 1'b0, 0, 0, "R3 unknown 00");

      // one empty group each
      cfg_write(1'b1, 8'h3F);
      run_cycle(6'h39, 24'h003000, 2'd2, 1'b0, 32'h0, 1'b0, 0, 0, "R4 no privilege");
      cfg_write(1'b1, 8'hC7);
      run_cycle(6'h39, 24'h003004, 2'd2, 1'b0, 32'h0, 1'b0, 0, 0, "R4 no space");
      cfg_write(1'b1, 8'hF8);
      run_cycle(6'h39, 24'h003008, 2'd2, 1'b0, 32'h0, 1'b0, 0, 0, "R4 no kind");

      // 16-bit-only limit
      cfg_write(1'b1, 8'h51);
      cfg_write(1'b0, 8'h03);
      run_cycle(6'h39, 24'h004000, 2'd2, 1'b0, 32'h0, 1'b0, 0, 0, "R5 D32 blocked");
      run_cycle(6'h39, 24'h004004, 2'd3, 1'b1, 32'h5, 1'b0, 0, 0, "R5 unaligned blocked");
      run_cycle(6'h39, 24'h004008, 2'd0, 1'b0, 32'h0, 1'b1, 0, 0, "R5 D08 ok");
      run_cycle(6'h39, 24'h00400C, 2'd1, 1'b1, 32'hBEEF, 1'b1, 0, 0, "R5 D16 ok");
      cfg_write(1'b0, 8'h01);
      run_cycle(6'h39, 24'h004010, 2'd3, 1'b0, 32'h0, 1'b1, 0, 0, "R5 unaligned ok");

      // posting
      cfg_write(1'b0, 8'h05);
      mem_lat = 4;
      run_cycle(6'h39, 24'h005000, 2'd2, 1'b1, 32'hA1B2C3D4, 1'b1, 1, 0, "R7 posted write");
      repeat (6) @(negedge clk);
      run_cycle(6'h39, 24'h005004, 2'd2, 1'b0, 32'h0, 1'b1, 0, 0, "R11 read not posted");

      // hold-off behind a long posted write
      mem_lat = 12;
      run_cycle(6'h39, 24'h006000, 2'd2, 1'b1, 32'h0F0F0F0F, 1'b1, 1, 0, "R7 long posted");
      run_cycle(6'h39, 24'h006004, 2'd2, 1'b0, 32'h0, 1'b1, 0, 0, "R8 read behind post");
      check(last_wait >= 10, "R8 read waited for drain", last_wait, 32'd10);

      // held valid after acknowledge
      mem_lat = 2;
      cfg_write(1'b0, 8'h01);
      run_cycle(6'h39, 24'h007000, 2'd2, 1'b0, 32'h0, 1'b1, 0, 6, "R10 held read");
      repeat (20) @(negedge clk);
      check(exp_q.size() == 0, "R6 all accepted cycles reached DRAM", exp_q.size(), 32'h0);

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule